// File: doc/BRIEF.md
# USB Control Endpoint Handshake Responder

This block chooses the bus-level answer that a device-side USB control endpoint gives to each packet identifier arriving from the host. A decoded token is presented with a one-cycle valid strobe. One clock later the block returns a single response code: acknowledge, negative acknowledge, stall, not-yet, start of data transmission, forced bit-stuff error, system error, bus timeout (no handshake at all) or ignore. The answer depends on the endpoint enable, the per-direction stall and prime bits, the buffer underflow and overflow flags, a setup-lockout flag and a packets-remaining hint from the current transfer descriptor.

The block keeps the per-direction prime and stall bits itself. Software sets them with request pulses. The data path clears a prime bit when it signals that a transfer is complete. An acknowledged SETUP is different from every other packet: it wipes both prime bits and both stall bits, so the data stage has to be primed again. It also raises a setup-status flag. A small phase machine has two states. In `ST_OPEN`, prime requests are accepted. An acknowledged SETUP moves it to `ST_SETUP_HELD`, where prime requests are refused. It returns to `ST_OPEN` when software pulses `setup_clr` and no new acknowledged SETUP arrives in the same cycle. If one does, it stays in `ST_SETUP_HELD`. Serialization, CRC, DMA and descriptor fetching are handled elsewhere.

Top module: `ctl_ep_responder`

## Requirements
- R1: `resp_vld` and `resp` are registered. They are updated on the clock edge that samples `pkt_vld`, so they are due one cycle after the strobe. `resp` is one-hot while `resp_vld` is high and all zero otherwise. Bit positions: 0 ACK, 1 NAK, 2 STALL, 3 NYET, 4 TX (send data), 5 BSERR (forced bit-stuff error), 6 SYSERR, 7 BTO (bus timeout), 8 IGNORE.
- R2: When `ep_enable` is low, every packet, including an invalid identifier, is answered with BTO.
- R3: On an enabled endpoint, an identifier other than the four valid ones is answered with IGNORE. The encodings of `pkt_pid` are SETUP=1, IN=2, OUT=3, PING=4.
- R4: A SETUP to an enabled endpoint is answered with ACK whatever the stall, prime and lockout state. The one exception is `rx_overflow` high, which gives SYSERR.
- R5: A SETUP answered with ACK clears both prime bits and both stall bits and sets `setup_flag`. All of these take effect one cycle after the strobe. A SETUP answered with SYSERR changes none of them.
- R6: An IN is answered as follows, in this priority order:
  - STALL if the IN stall bit (`stall_q[1]`) is set;
  - otherwise NAK under `setup_lockout` or when the IN prime bit (`prime_q[1]`) is clear;
  - otherwise BSERR under `tx_underflow`;
  - otherwise TX.
- R7: An OUT is answered as follows, in this priority order:
  - STALL if `stall_q[0]` is set;
  - otherwise NAK under lockout, when `prime_q[0]` is clear, or under `rx_overflow`;
  - otherwise ACK when `pkts_left` is high and NYET when it is low. `rx_take` is raised together with ACK or NYET and is low for every other response.
- R8: A PING is answered with STALL if `stall_q[0]` is set. Otherwise it gets NAK under lockout or when `prime_q[0]` is clear, and ACK in all other cases.
- R9: A `prime_req[d]` pulse sets `prime_q[d]` (0 = OUT, 1 = IN) one cycle later, but only while `setup_flag` is low. `xfer_done[d]` clears the bit, and a clear wins over a request in the same cycle.
- R10: `setup_clr` returns the phase machine from `ST_SETUP_HELD` to `ST_OPEN`. An acknowledged SETUP in the same cycle wins and keeps it held.
- R11: A `stall_set[d]` pulse sets `stall_q[d]`. An acknowledged SETUP in the same cycle wins and leaves it clear.
- R12: After reset, `resp_vld`, `resp`, `rx_take`, `prime_q`, `stall_q` and `setup_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_vld | input | 1 | Packet identifier strobe |
| pkt_pid | input | 3 | Decoded identifier: 1 SETUP, 2 IN, 3 OUT, 4 PING, other invalid |
| ep_enable | input | 1 | Endpoint enabled |
| setup_lockout | input | 1 | Data stage held off after a setup |
| tx_underflow | input | 1 | Transmit buffer would underflow |
| rx_overflow | input | 1 | Receive buffer would overflow |
| pkts_left | input | 1 | Transfer descriptor has packets remaining |
| stall_set | input | 2 | Per-direction stall request (0 OUT, 1 IN) |
| prime_req | input | 2 | Per-direction prime request |
| xfer_done | input | 2 | Per-direction transfer completion |
| setup_clr | input | 1 | Software clear of the setup-status flag |
| resp_vld | output | 1 | Response valid |
| resp | output | 9 | One-hot response code |
| rx_take | output | 1 | Received data is accepted |
| prime_q | output | 2 | Prime status per direction |
| stall_q | output | 2 | Stall status per direction |
| setup_flag | output | 1 | Setup-status flag (phase machine held) |

## Verification
All outputs have the same latency. The response code, `rx_take`, and the prime, stall and flag updates caused by a strobe or a request pulse all appear on the edge that samples the input, so they are due exactly one cycle later. The bench drives every input on a falling edge and compares all outputs on the next falling edge against a model that it advances once per cycle. Because a response decision reads the state as it was before that edge, the model computes the expected response from its old state first and only then updates its state. Directed sequences hit the same-cycle priority cases: a clear against a prime request, an acknowledged SETUP against a stall request or a flag clear, and a prime attempt while the flag is held.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
    localparam int PID_W  = 3;
    localparam int NDIR   = 2;
    localparam int RESP_W = 9;

    localparam int DIR_OUT = 0;
    localparam int DIR_IN  = 1;

    typedef enum logic [PID_W-1:0] {
        PID_BAD0  = 3'd0,
        PID_SETUP = 3'd1,
        PID_IN    = 3'd2,
        PID_OUT   = 3'd3,
        PID_PING  = 3'd4,
        PID_BAD5  = 3'd5,
        PID_BAD6  = 3'd6,
        PID_BAD7  = 3'd7
    } pid_e;

    typedef enum logic [3:0] {
        RC_ACK    = 4'd0,
        RC_NAK    = 4'd1,
        RC_STALL  = 4'd2,
        RC_NYET   = 4'd3,
        RC_TX     = 4'd4,
        RC_BSERR  = 4'd5,
        RC_SYSERR = 4'd6,
        RC_BTO    = 4'd7,
        RC_IGNORE = 4'd8
    } rcode_e;

    typedef enum logic {
        ST_OPEN       = 1'b0,
        ST_SETUP_HELD = 1'b1
    } phase_e;
endpackage

// File: rtl/ctl_ep_resp_decode.sv
module ctl_ep_resp_decode
    import ctl_ep_pkg::*;
(
    input  logic [PID_W-1:0] pid,
    input  logic             ep_enable,
    input  logic             lockout,
    input  logic             tx_underflow,
    input  logic             rx_overflow,
    input  logic             pkts_left,
    input  logic [NDIR-1:0]  stall,
    input  logic [NDIR-1:0]  prime,
    output rcode_e           code,
    output logic             take,
    output logic             setup_hit
);
    pid_e pid_t;
    logic out_blocked;
    logic in_blocked;

    assign pid_t       = pid_e'(pid);
    assign out_blocked = lockout | ~prime[DIR_OUT];
    assign in_blocked  = lockout | ~prime[DIR_IN];

    always_comb begin
        code      = RC_IGNORE;
        take      = 1'b0;
        setup_hit = 1'b0;
        if (!ep_enable) begin
            code = RC_BTO;
        end else begin
            unique case (pid_t)
                PID_SETUP: begin
                    if (rx_overflow) begin
                        code = RC_SYSERR;
                    end else begin
                        code      = RC_ACK;
                        setup_hit = 1'b1;
                    end
                end
                PID_IN: begin
                    if (stall[DIR_IN])      code = RC_STALL;
                    else if (in_blocked)    code = RC_NAK;
                    else if (tx_underflow)  code = RC_BSERR;
                    else                    code = RC_TX;
                end
                PID_OUT: begin
                    if (stall[DIR_OUT])                  code = RC_STALL;
                    else if (out_blocked || rx_overflow) code = RC_NAK;
                    else begin
                        code = pkts_left ? RC_ACK : RC_NYET;
                        take = 1'b1;
                    end
                end
                PID_PING: begin
                    if (stall[DIR_OUT])   code = RC_STALL;
                    else if (out_blocked) code = RC_NAK;
                    else                  code = RC_ACK;
                end
                default: code = RC_IGNORE;
            endcase
        end
    end
endmodule

// File: rtl/ctl_ep_phase_fsm.sv
module ctl_ep_phase_fsm
    import ctl_ep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic setup_hit,
    input  logic setup_clr,
    output logic setup_flag,
    output logic prime_ok
);
    phase_e state_q;
    phase_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (setup_hit) state_d = ST_SETUP_HELD;
            end
            ST_SETUP_HELD: begin
                if (setup_clr && !setup_hit) state_d = ST_OPEN;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        setup_flag = 1'b0;
        prime_ok   = 1'b0;
        unique case (state_q)
            ST_OPEN:       prime_ok   = 1'b1;
            ST_SETUP_HELD: setup_flag = 1'b1;
            default:       prime_ok   = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctl_ep_dir_state.sv
module ctl_ep_dir_state (
    input  logic clk,
    input  logic rst_n,
    input  logic prime_req,
    input  logic prime_ok,
    input  logic xfer_done,
    input  logic stall_set,
    input  logic setup_hit,
    output logic prime_q,
    output logic stall_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prime_q <= 1'b0;
            stall_q <= 1'b0;
        end else begin
            if (setup_hit || xfer_done)      prime_q <= 1'b0;
            else if (prime_req && prime_ok)  prime_q <= 1'b1;

            if (setup_hit)                   stall_q <= 1'b0;
            else if (stall_set)              stall_q <= 1'b1;
        end
    end
endmodule

// File: rtl/ctl_ep_responder.sv
module ctl_ep_responder
    import ctl_ep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_vld,
    input  logic [PID_W-1:0]  pkt_pid,
    input  logic              ep_enable,
    input  logic              setup_lockout,
    input  logic              tx_underflow,
    input  logic              rx_overflow,
    input  logic              pkts_left,
    input  logic [NDIR-1:0]   stall_set,
    input  logic [NDIR-1:0]   prime_req,
    input  logic [NDIR-1:0]   xfer_done,
    input  logic              setup_clr,
    output logic              resp_vld,
    output logic [RESP_W-1:0] resp,
    output logic              rx_take,
    output logic [NDIR-1:0]   prime_q,
    output logic [NDIR-1:0]   stall_q,
    output logic              setup_flag
);
    rcode_e code_c;
    logic   take_c;
    logic   setup_c;
    logic   setup_hit;
    logic   prime_ok;

    ctl_ep_resp_decode u_dec (
        .pid          (pkt_pid),
        .ep_enable    (ep_enable),
        .lockout      (setup_lockout),
        .tx_underflow (tx_underflow),
        .rx_overflow  (rx_overflow),
        .pkts_left    (pkts_left),
        .stall        (stall_q),
        .prime        (prime_q),
        .code         (code_c),
        .take         (take_c),
        .setup_hit    (setup_c)
    );

    assign setup_hit = pkt_vld & setup_c;

    ctl_ep_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .setup_hit  (setup_hit),
        .setup_clr  (setup_clr),
        .setup_flag (setup_flag),
        .prime_ok   (prime_ok)
    );

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        ctl_ep_dir_state u_dir (
            .clk       (clk),
            .rst_n     (rst_n),
            .prime_req (prime_req[d]),
            .prime_ok  (prime_ok),
            .xfer_done (xfer_done[d]),
            .stall_set (stall_set[d]),
            .setup_hit (setup_hit),
            .prime_q   (prime_q[d]),
            .stall_q   (stall_q[d])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_vld <= 1'b0;
            resp     <= '0;
            rx_take  <= 1'b0;
        end else begin
            resp_vld <= pkt_vld;
            resp     <= pkt_vld ? (RESP_W'(1) << code_c) : '0;
            rx_take  <= pkt_vld & take_c;
        end
    end
endmodule

// File: rtl/ctl_ep_responder_chk.sv
module ctl_ep_responder_chk
    import ctl_ep_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pkt_vld,
    input logic [PID_W-1:0]  pkt_pid,
    input logic              ep_enable,
    input logic              rx_overflow,
    input logic [NDIR-1:0]   prime_req,
    input logic              setup_clr,
    input logic              resp_vld,
    input logic [RESP_W-1:0] resp,
    input logic              rx_take,
    input logic [NDIR-1:0]   prime_q,
    input logic [NDIR-1:0]   stall_q,
    input logic              setup_flag
);
    AST_RESP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld |-> $countones(resp) == 1); // R1
    AST_RESP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_vld |-> (resp == '0 && !rx_take)); // R1
    AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_vld |=> resp_vld); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_vld |=> !resp_vld); // R1
    AST_DISABLED_BTO: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_vld && !ep_enable) |=> resp[RC_BTO]); // R2
    AST_SETUP_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_vld && ep_enable && pkt_pid == PID_SETUP && !rx_overflow)
        |=> (resp[RC_ACK] && prime_q == '0 && stall_q == '0 && setup_flag)); // R5
    AST_SETUP_SYSERR: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_vld && ep_enable && pkt_pid == PID_SETUP && rx_overflow)
        |=> resp[RC_SYSERR]); // R4
    AST_PRIME_HELD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_flag && !prime_q[DIR_OUT]) |=> !prime_q[DIR_OUT]); // R9
    AST_PRIME_HELD_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_flag && !prime_q[DIR_IN]) |=> !prime_q[DIR_IN]); // R9
    AST_TAKE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |-> (resp[RC_ACK] || resp[RC_NYET])); // R7
endmodule

bind ctl_ep_responder ctl_ep_responder_chk chk_i (.*);

// File: tb/ctl_ep_responder_tb_top.sv
module ctl_ep_responder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_vld = 1'b0;
    logic [2:0] pkt_pid = '0;
    logic       ep_enable = 1'b0;
    logic       setup_lockout = 1'b0;
    logic       tx_underflow = 1'b0;
    logic       rx_overflow = 1'b0;
    logic       pkts_left = 1'b0;
    logic [1:0] stall_set = '0;
    logic [1:0] prime_req = '0;
    logic [1:0] xfer_done = '0;
    logic       setup_clr = 1'b0;
    logic       resp_vld;
    logic [8:0] resp;
    logic       rx_take;
    logic [1:0] prime_q;
    logic [1:0] stall_q;
    logic       setup_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [1:0] m_prime = '0;
    logic [1:0] m_stall = '0;
    logic       m_flag  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_ep_responder dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_vld(pkt_vld), .pkt_pid(pkt_pid),
        .ep_enable(ep_enable), .setup_lockout(setup_lockout),
        .tx_underflow(tx_underflow), .rx_overflow(rx_overflow),
        .pkts_left(pkts_left), .stall_set(stall_set), .prime_req(prime_req),
        .xfer_done(xfer_done), .setup_clr(setup_clr), .resp_vld(resp_vld),
        .resp(resp), .rx_take(rx_take), .prime_q(prime_q), .stall_q(stall_q),
        .setup_flag(setup_flag)
    );

    // Bit index of expected response (R1 positions); tag names the rule.
    function automatic int exp_bit(output string tag);
        tag = "R3";
        if (!ep_enable) begin tag = "R2"; return 7; end
        case (pkt_pid)
            3'd1: begin tag = "R4"; return rx_overflow ? 6 : 0; end
            3'd2: begin
                tag = "R6";
                if (m_stall[1]) return 2;
                if (setup_lockout || !m_prime[1]) return 1;
                return tx_underflow ? 5 : 4;
            end
            3'd3: begin
                tag = "R7";
                if (m_stall[0]) return 2;
                if (setup_lockout || !m_prime[0] || rx_overflow) return 1;
                return pkts_left ? 0 : 3;
            end
            3'd4: begin
                tag = "R8";
                if (m_stall[0]) return 2;
                if (setup_lockout || !m_prime[0]) return 1;
                return 0;
            end
            default: return 8;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge with inputs already set; checks one cycle later.
    task automatic step();
        string     tag;
        int        eb;
        logic [8:0] e_resp;
        logic      e_take;
        logic      shit;
        logic [1:0] n_prime;
        logic [1:0] n_stall;
        logic      n_flag;
        eb     = exp_bit(tag);
        e_resp = pkt_vld ? (9'd1 << eb) : 9'd0;
        e_take = pkt_vld && ep_enable && pkt_pid == 3'd3 && (eb == 0 || eb == 3);
        shit   = pkt_vld && ep_enable && pkt_pid == 3'd1 && !rx_overflow;
        for (int d = 0; d < 2; d++) begin
            if (shit || xfer_done[d])           n_prime[d] = 1'b0;
            else if (prime_req[d] && !m_flag)   n_prime[d] = 1'b1;
            else                                n_prime[d] = m_prime[d];
            if (shit)                           n_stall[d] = 1'b0;
            else if (stall_set[d])              n_stall[d] = 1'b1;
            else                                n_stall[d] = m_stall[d];
        end
        if (shit)                 n_flag = 1'b1;
        else if (setup_clr)       n_flag = 1'b0;
        else                      n_flag = m_flag;
        @(negedge clk);
        check(pkt_vld ? tag : "R1", "resp", 16'(resp), 16'(e_resp));
        check("R1", "resp_vld", 16'(resp_vld), 16'(pkt_vld));
        check("R7", "rx_take", 16'(rx_take), 16'(e_take));
        check(shit ? "R5" : "R9", "prime_q", 16'(prime_q), 16'(n_prime));
        check(shit ? "R5" : "R11", "stall_q", 16'(stall_q), 16'(n_stall));
        check(shit ? "R5" : "R10", "setup_flag", 16'(setup_flag), 16'(n_flag));
        m_prime = n_prime;
        m_stall = n_stall;
        m_flag  = n_flag;
    endtask

    task automatic idle();
        pkt_vld = 0; pkt_pid = 0; stall_set = 0; prime_req = 0;
        xfer_done = 0; setup_clr = 0; setup_lockout = 0;
        tx_underflow = 0; rx_overflow = 0; pkts_left = 0; ep_enable = 1;
    endtask

    task automatic pkt(input logic [2:0] p);
        idle(); pkt_vld = 1; pkt_pid = p;
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5eed_0c7e);
        idle();
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", "reset resp_vld", 16'(resp_vld), 16'd0);
        check("R12", "reset resp", 16'(resp), 16'd0);
        check("R12", "reset state", 16'({rx_take, prime_q, stall_q, setup_flag}), 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: R2 invalid pid on disabled endpoint gives BTO
        pkt(3'd6); ep_enable = 0; step();
        // R3 invalid pid ignored
        pkt(3'd7); step();
        // R8 / R6 / R7 unprimed -> NAK
        pkt(3'd4); step();
        pkt(3'd2); step();
        // R9 prime both and R11 stall IN
        idle(); prime_req = 2'b11; stall_set = 2'b10; step();
        pkt(3'd2); step();                       // R6 stall wins
        pkt(3'd3); pkts_left = 0; step();        // R7 NYET
        pkt(3'd3); pkts_left = 1; step();        // R7 ACK
        pkt(3'd3); rx_overflow = 1; step();      // R7 overflow NAK
        pkt(3'd4); setup_lockout = 1; step();    // R8 lockout NAK
        // R4 SETUP with overflow -> SYSERR, no state change
        pkt(3'd1); rx_overflow = 1; step();
        // R5/R11 SETUP acked with stall request same cycle
        pkt(3'd1); stall_set = 2'b11; step();
        // R9 prime refused while flag held
        idle(); prime_req = 2'b11; step();
        // R10 clear and acked SETUP same cycle: stays held
        pkt(3'd1); setup_clr = 1; step();
        idle(); setup_clr = 1; step();
        // R9 clear wins over request
        idle(); prime_req = 2'b01; xfer_done = 2'b01; step();
        idle(); prime_req = 2'b10; step();
        pkt(3'd2); tx_underflow = 1; step();     // R6 BSERR
        pkt(3'd2); step();                       // R6 TX
        idle(); xfer_done = 2'b10; step();

        // Constrained random
        for (int i = 0; i < N_RANDOM; i++) begin
            int r;
            idle();
            pkt_vld       = ($urandom_range(0, 3) != 0);
            r             = $urandom_range(0, 15);
            pkt_pid       = (r < 3) ? 3'd1 : (r < 7) ? 3'd2 : (r < 11) ? 3'd3 :
                            (r < 14) ? 3'd4 : 3'($urandom_range(5, 7));
            ep_enable     = ($urandom_range(0, 9) != 0);
            setup_lockout = ($urandom_range(0, 7) == 0);
            tx_underflow  = ($urandom_range(0, 5) == 0);
            rx_overflow   = ($urandom_range(0, 5) == 0);
            pkts_left     = 1'($urandom_range(0, 1));
            stall_set     = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            prime_req     = ($urandom_range(0, 2) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            xfer_done     = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            setup_clr     = ($urandom_range(0, 3) == 0);
            step();
        end
        idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule